// File: doc/BRIEF.md
# Timed-Conversion Serial ADC Reader

This block takes one sample from a serial analog-to-digital converter that is started by a conversion strobe and that has no busy or ready output. When a start request arrives, the block raises the strobe of the selected converter and holds it high for a fixed wait. That wait is long enough for the slowest supported converter to finish. The block then releases the strobe and drives a serial clock, reading the result one bit per clock period with the most significant bit first.

The number of result bits is chosen with each request, so 16-, 18- and 24-bit parts can share one reader. The received value is a two's-complement number. The block sign-extends it to 32 bits and presents it with a one-cycle done pulse. Several converters hang off the block, one strobe, clock and data line each, and a channel index picks one of them for each request. All intervals are counted in system clock cycles, derived from the clock frequency parameter and rounded up. The data line passes through a two-flop synchronizer, and the sampling point is moved later to cover that delay.

Top module: `timed_adc_reader`

## Requirements
- R1: Out of reset, and whenever no transfer is running, every strobe and every serial clock output is low, `busy` is low and `result` reads 0 until the first completed read.
- R2: An accepted request raises the strobe of the selected channel in the cycle after `start` is sampled. The strobe stays high for exactly CONV_CYC = ceil(CONV_NS × CLK_FREQ_HZ / 1e9) cycles (28 at 50 MHz) and is then released. No serial clock edge occurs while it is high.
- R3: After the strobe drops, each bit takes a low phase of PH_CYC+2 cycles followed by a high phase of PH_CYC cycles, where PH_CYC = ceil(PHASE_NS × CLK_FREQ_HZ / 1e9) (1 at 50 MHz). Exactly `width` clock pulses are produced.
- R4: The data line is sampled at the end of each low phase, after the synchronizer delay. The first bit sampled is the most significant, and each new bit enters at bit 0 of the accumulated word.
- R5: If received bit `width`-1 is 1, `result` has every bit from `width` to 31 set to 1. Otherwise those bits are 0. At a width of 32 the word is passed through unchanged.
- R6: `done` is high for exactly one cycle, in the cycle after the last serial clock high phase. `result` changes only in that cycle and holds its value until the next completed read.
- R7: A request whose channel index is at or above NCH, or whose width is 0 or above 32, produces a one-cycle `err` pulse in the next cycle. It starts no transfer and leaves `result` unchanged.
- R8: A `start` that arrives while a transfer is running is ignored. It produces no error and does not change the running transfer. A `start` in the done cycle is accepted.
- R9: `busy` is high from the cycle after acceptance through the last serial clock high phase, and low in the done cycle.
- R10: Only the selected channel's strobe and serial clock toggle during a transfer. Only that channel's data line is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one read |
| chan | input | CHW | Converter index for the request |
| width | input | 6 | Result bits to read (1 to 32) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for a rejected request |
| result | output | 32 | Sign-extended sample |
| adc_conv | output | NCH | Conversion strobes, one per converter |
| adc_sck | output | NCH | Serial clocks, one per converter |
| adc_sdo | input | NCH | Serial data from each converter |

## Verification
The bench aims at the following corner cases:
- **Sign bit at each width.** Negative samples at widths of 1, 16, 18, 24 and 32 bits. A design that tests the wrong bit, or builds its extension mask one position off, would return a positive or corrupted word.
- **Sampling point and bit order.** The bench model changes the data line just after each rising serial clock. Unselected channels carry the inverse data. A design that samples before the synchronizer has settled, or reads the wrong channel, would return shifted or inverted bits.
- **Rejected and ignored requests.** Out-of-range channels, widths of 0 and 33, a start in the middle of a transfer, and a start in the done cycle. A design that mishandles these would either start a stray strobe or drop a back-to-back request.
- **Strobe length.** Counted cycle by cycle against the model. A design that counts it one cycle short would break the required minimum time.

// File: rtl/timed_adc_reader.sv
module timed_adc_reader #(
  parameter int CLK_FREQ_HZ = 50_000_000,
  parameter int NCH         = 3,
  parameter int CONV_NS     = 550,
  parameter int PHASE_NS    = 20,
  parameter int CHW         = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CHW-1:0]   chan,
  input  logic [5:0]       width,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [31:0]      result,
  output logic [NCH-1:0]   adc_conv,
  output logic [NCH-1:0]   adc_sck,
  input  logic [NCH-1:0]   adc_sdo
);
  localparam longint NS_PER_S = 64'd1_000_000_000;
  localparam longint CONV_RAW = (longint'(CONV_NS) * CLK_FREQ_HZ + NS_PER_S - 1) / NS_PER_S;
  localparam longint PH_RAW   = (longint'(PHASE_NS) * CLK_FREQ_HZ + NS_PER_S - 1) / NS_PER_S;
  localparam int CONV_CYC = (CONV_RAW < 1) ? 1 : int'(CONV_RAW);
  localparam int PH_CYC   = (PH_RAW < 1) ? 1 : int'(PH_RAW);
  localparam int LOW_CYC  = PH_CYC + 2;
  localparam int HIGH_CYC = PH_CYC;
  localparam int CW       = $clog2(CONV_CYC + LOW_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_LOW, S_HIGH} st_t;

  st_t            st;
  logic [CHW-1:0] ch_q;
  logic [5:0]     wid_q, nbit;
  logic [CW-1:0]  cnt;
  logic [31:0]    acc;
  logic [1:0]     sync;
  logic           conv_q, sck_q, sel_sdo;

  wire req_ok   = (int'(chan) < NCH) && (width != 6'd0) && (width <= 6'd32);
  wire cnt_zero = (cnt == '0);
  wire last_bit = (nbit == wid_q - 6'd1);
  wire [31:0] ext_mask = 32'hFFFF_FFFF << wid_q;
  wire [31:0] ext_val  = acc[wid_q[4:0] - 5'd1] ? (acc | ext_mask) : acc;

  always_comb begin
    sel_sdo = 1'b0;
    for (int i = 0; i < NCH; i++)
      if (ch_q == CHW'(i)) sel_sdo = adc_sdo[i];
  end

  for (genvar g = 0; g < NCH; g++) begin : g_pins
    assign adc_conv[g] = conv_q && (ch_q == CHW'(g));
    assign adc_sck[g]  = sck_q  && (ch_q == CHW'(g));
  end

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) sync <= '0;
    else        sync <= {sync[0], sel_sdo};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ch_q   <= '0;
      wid_q  <= '0;
      nbit   <= '0;
      cnt    <= '0;
      acc    <= '0;
      conv_q <= 1'b0;
      sck_q  <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE: begin
          sck_q <= 1'b0;
          if (start) begin
            if (req_ok) begin
              ch_q   <= chan;
              wid_q  <= width;
              acc    <= '0;
              nbit   <= '0;
              conv_q <= 1'b1;
              cnt    <= CW'(CONV_CYC - 1);
              st     <= S_CONV;
            end else begin
              err <= 1'b1;
            end
          end
        end
        S_CONV: begin
          if (cnt_zero) begin
            conv_q <= 1'b0;
            cnt    <= CW'(LOW_CYC - 1);
            st     <= S_LOW;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_LOW: begin
          if (cnt_zero) begin
            acc   <= {acc[30:0], sync[1]};
            sck_q <= 1'b1;
            cnt   <= CW'(HIGH_CYC - 1);
            st    <= S_HIGH;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_HIGH: begin
          if (cnt_zero) begin
            sck_q <= 1'b0;
            if (last_bit) begin
              result <= ext_val;
              done   <= 1'b1;
              st     <= S_IDLE;
            end else begin
              nbit <= nbit + 6'd1;
              cnt  <= CW'(LOW_CYC - 1);
              st   <= S_LOW;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/timed_adc_reader_chk.sv
module timed_adc_reader_chk #(
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           err,
  input logic [31:0]    result,
  input logic [NCH-1:0] adc_conv,
  input logic [NCH-1:0] adc_sck
);
  // R2
  conv_sck_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((|adc_conv) && (|adc_sck)));
  // R10
  conv_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(adc_conv));
  // R10
  sck_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(adc_sck));
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);
  // R7
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !(|adc_conv)));
  // R9
  sck_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (|adc_sck) |-> busy);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !((|adc_sck) || (|adc_conv)));
endmodule

bind timed_adc_reader timed_adc_reader_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .result(result), .adc_conv(adc_conv), .adc_sck(adc_sck)
);

// File: tb/sim_timed_adc_reader.sv
module sim_timed_adc_reader;
  localparam int NCH = 3;
  localparam int CHW = 2;
  localparam int CONV = 28;
  localparam int LOWC = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [CHW-1:0] chan = '0;
  logic [5:0] width = '0;
  logic busy, done, err;
  logic [31:0] result;
  logic [NCH-1:0] adc_conv, adc_sck, adc_sdo;

  always #10 clk = ~clk;

  timed_adc_reader #(.CLK_FREQ_HZ(50_000_000), .NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .chan(chan), .width(width),
    .busy(busy), .done(done), .err(err), .result(result),
    .adc_conv(adc_conv), .adc_sck(adc_sck), .adc_sdo(adc_sdo)
  );

  int checks = 0, failures = 0;
  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] sx(logic [31:0] v, int w);
    longint m = longint'(v) & ((64'd1 << w) - 1);
    if (((m >> (w - 1)) & 1) == 1) m = m - (64'sd1 << w);
    return m[31:0];
  endfunction

  // converter model: new data just after each rising serial clock
  logic [31:0] samp = '0;
  int samp_w = 16, act_ch = 0, bidx = 0;
  logic bitv = 1'b0;
  logic [NCH-1:0] pconv = '0, psck = '0;
  always_comb begin
    adc_sdo = {NCH{~bitv}};
    adc_sdo[act_ch] = bitv;
  end
  always @(posedge clk) begin
    #1;
    if (adc_conv[act_ch] && !pconv[act_ch]) begin
      bidx = samp_w - 1;
      bitv = samp[bidx];
    end else if (adc_sck[act_ch] && !psck[act_ch]) begin
      bidx = bidx - 1;
      bitv = (bidx >= 0) ? samp[bidx] : 1'b0;
    end
    pconv = adc_conv;
    psck = adc_sck;
  end

  // reference model: queue of per-cycle codes (bit0 strobe, bit1 sck, bit2 done)
  int q[$];
  int mch = 0;
  logic [31:0] mres = '0, pend = '0;
  logic exp_err = 1'b0;
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); mres = '0; exp_err = 1'b0;
    end else begin
      automatic bit prev_busy = (q.size() > 0) && ((q[0] & 4) == 0);
      if (q.size() > 0) void'(q.pop_front());
      exp_err = 1'b0;
      if (!prev_busy && start) begin
        if (int'(chan) < NCH && width >= 1 && width <= 32) begin
          mch = int'(chan);
          pend = sx(samp, int'(width));
          for (int i = 0; i < CONV; i++) q.push_back(1);
          for (int b = 0; b < int'(width); b++) begin
            for (int i = 0; i < LOWC; i++) q.push_back(0);
            q.push_back(2);
          end
          q.push_back(4);
        end else exp_err = 1'b1;
      end
      if (q.size() > 0 && q[0] == 4) mres = pend;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      automatic int code = (q.size() > 0) ? q[0] : 0;
      automatic logic [NCH-1:0] sel = NCH'(1) << mch;
      chk("R2 strobe", adc_conv, (code & 1) ? sel : '0);
      chk("R3 sck", adc_sck, (code & 2) ? sel : '0);
      chk("R6 done", done, (code & 4) != 0);
      chk("R9 busy", busy, (q.size() > 0) && ((code & 4) == 0));
      chk("R7 err", err, exp_err);
      chk("R5 result", result, mres);
    end
  end

  task automatic go(int ch, int w, logic [31:0] v);
    @(negedge clk);
    samp = v; samp_w = w; act_ch = (ch < NCH) ? ch : 0;
    chan = CHW'(ch); width = 6'(w); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd(int ch, int w, logic [31:0] v, string tag);
    go(ch, w, v);
    wait_idle();
    chk(tag, result, sx(v, w));
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset conv", adc_conv, 0);
    chk("R1 reset sck", adc_sck, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset result", result, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(0, 16, 32'h0000_1234, "R4 w16 positive");
    rd(1, 16, 32'h0000_8001, "R5 w16 negative");
    rd(2, 18, 32'h0002_A5A5, "R5 w18 negative");
    rd(0, 24, 32'h0080_0003, "R5 w24 negative");
    rd(1, 24, 32'h007F_FFFE, "R4 w24 positive");
    rd(2, 32, 32'hDEAD_BEEF, "R5 w32 passthrough");
    rd(0, 1, 32'h0000_0001, "R5 w1 negative");
    // R7 rejected requests
    go(3, 16, 32'h0000_FFFF); wait_idle();
    chk("R7 bad channel keeps result", result, 32'hFFFF_FFFF);
    go(0, 0, 32'h0); wait_idle();
    go(0, 33, 32'h0); wait_idle();
    chk("R7 bad width keeps result", result, 32'hFFFF_FFFF);
    // R8 start while busy is ignored
    go(1, 18, 32'h0001_0000);
    repeat (10) @(negedge clk);
    chan = 2'd2; width = 6'd24; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    chk("R8 busy start ignored", result, sx(32'h0001_0000, 18));
    // R8 start during the done cycle is accepted
    go(2, 16, 32'h0000_7FFF);
    while (q.size() != 1) @(negedge clk);
    samp = 32'h00FF_F000; samp_w = 24; act_ch = 0;
    chan = 2'd0; width = 6'd24; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 first result", result, 32'h0000_7FFF);
    wait_idle();
    chk("R8 back-to-back result", result, sx(32'h00FF_F000, 24));
    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule